// File: doc/BRIEF.md
# Clock-Gated Low-Power Arithmetic Logic Unit

This block is a registered 16-bit arithmetic logic unit with eight operations picked by a 3-bit opcode. Each operation takes operands `a` and `b` and produces a result. The result, a zero flag and a carry flag are stored in registers and driven out one clock after the operands are applied with the unit enabled.

The block saves power in two ways while it sits idle.

- **Clock gating.** The clock to the output registers is stopped whenever `enable` is low. A glitch-free gate does this: a latch, transparent while the clock is low, captures the request, and the latch output is ANDed with the clock. A request raised in mid-cycle therefore cannot cut a short pulse.
- **Operand isolation.** Both operands are forced to zero before they reach the datapath. The adder, shifter and multiplier then stop toggling.

A synchronous reset clears the registers. Reset also opens the gate, so it works while the unit is disabled.

Top module: `alu_lp_top`

## Requirements
- R1: Opcode 3'b000 adds `a` and `b`. The result is the low 16 bits of the sum, and carry is bit 16 of the 17-bit sum.
- R2: Opcode 3'b001 computes `a - b` modulo 2^16. Carry is 1 exactly when `a < b` as unsigned numbers (a borrow).
- R3: Opcodes 3'b010, 3'b011 and 3'b100 give bitwise AND, OR and XOR, and carry is always 0 for them.
- R4: Opcode 3'b101 shifts `a` left logically by `b[3:0]`, with zeros filling in. Carry is the last bit shifted out, `a[16-n]` for a shift amount n > 0, and 0 when n = 0.
- R5: Opcode 3'b110 shifts `a` right logically by `b[3:0]`, with zeros filling in. Carry is the last bit shifted out, `a[n-1]` for n > 0, and 0 when n = 0.
- R6: Opcode 3'b111 returns the low 16 bits of the unsigned product. Carry is 1 when any of the upper 16 product bits is set.
- R7: After an enabled update, the zero flag is 1 exactly when the stored 16-bit result is zero.
- R8: With `enable` high before a rising clock edge, result and flags show that cycle's operation right after that edge.
- R9: While `enable` is low, the result and both flags hold their values whatever the opcode and operands do. The datapath sees all-zero operands and so produces a zero result with no carry.
- R10: If `enable` rises while the clock is high, no register update happens in that clock period. The first update comes at the next rising edge.
- R11: A synchronous active-high reset clears the result, zero and carry to 0, and it does so even while `enable` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Unit enable; low stops the register clock and isolates operands |
| opcode | input | 3 | Operation select |
| a | input | 16 | First operand |
| b | input | 16 | Second operand (shift amount in bits 3:0 for shifts) |
| result | output | 16 | Registered result |
| zero | output | 1 | Registered zero flag |
| carry | output | 1 | Registered carry / borrow / shift-out / overflow flag |

## Verification
Every opcode is crossed with a fixed set of edge operands: zero, one, all ones, the sign bit alone, the largest positive value, alternating bit patterns and byte masks.

- **Operand cross.** This separates carry-out from no carry, borrow from no borrow, and a product that overflows from one that does not. It also produces results that are zero through wrap-around rather than from zero inputs.
- **Shift sweep.** Both shifts are swept over all sixteen amounts. This tells the shift-by-zero carry rule apart from the last-bit-out rule at every position.
- **Gating patterns.** Separate runs toggle the operands while disabled, which must leave the outputs frozen. Others raise enable in the middle of a high clock phase, which must not produce an early update, and assert reset while disabled.

// File: rtl/alu_lp_pkg.sv
package alu_lp_pkg;
  localparam int OPW = 3;

  typedef enum logic [OPW-1:0] {
    OP_ADD = 3'b000,
    OP_SUB = 3'b001,
    OP_AND = 3'b010,
    OP_OR  = 3'b011,
    OP_XOR = 3'b100,
    OP_SHL = 3'b101,
    OP_SHR = 3'b110,
    OP_MUL = 3'b111
  } alu_op_e;
endpackage

// File: rtl/alu_clock_gate.sv
// Latch-based glitch-free clock gate: the request is captured while clk is low
// and held through the high phase, so the gated clock only ever follows whole
// high phases of clk.
module alu_clock_gate (
  input  logic clk,
  input  logic gate_req,
  output logic gclk
);
  logic req_held;

  always_latch begin
    if (!clk) req_held <= gate_req;
  end

  assign gclk = clk & req_held;
endmodule

// File: rtl/alu_operand_isolate.sv
// Forces the operands to zero while the unit is idle.
module alu_operand_isolate #(
  parameter int W = 16
) (
  input  logic         active,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] a_out,
  output logic [W-1:0] b_out
);
  assign a_out = active ? a_in : '0;
  assign b_out = active ? b_in : '0;
endmodule

// File: rtl/alu_datapath.sv
// Combinational operation unit. Each function returns {carry, result}.
module alu_datapath
  import alu_lp_pkg::*;
#(
  parameter int W = 16
) (
  input  alu_op_e      op,
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] res,
  output logic         cy
);
  localparam int SHW = $clog2(W);

  function automatic logic [W:0] f_add(input logic [W-1:0] p, input logic [W-1:0] q);
    return {1'b0, p} + {1'b0, q};
  endfunction

  // Bit W of the widened difference is the unsigned borrow.
  function automatic logic [W:0] f_sub(input logic [W-1:0] p, input logic [W-1:0] q);
    return {1'b0, p} - {1'b0, q};
  endfunction

  // The last bit shifted out lands in position W of the widened value.
  function automatic logic [W:0] f_shl(input logic [W-1:0] p, input logic [SHW-1:0] n);
    logic [W:0] wide;
    wide = {1'b0, p} << n;
    return wide;
  endfunction

  // The last bit shifted out lands in position 0 of the widened value.
  function automatic logic [W:0] f_shr(input logic [W-1:0] p, input logic [SHW-1:0] n);
    logic [W:0] wide;
    wide = {p, 1'b0} >> n;
    return {wide[0], wide[W:1]};
  endfunction

  function automatic logic [W:0] f_mul(input logic [W-1:0] p, input logic [W-1:0] q);
    logic [2*W-1:0] prod;
    prod = p * q;
    return {|prod[2*W-1:W], prod[W-1:0]};
  endfunction

  logic [W:0] packed_out;

  always_comb begin
    unique case (op)
      OP_ADD:  packed_out = f_add(x, y);
      OP_SUB:  packed_out = f_sub(x, y);
      OP_AND:  packed_out = {1'b0, x & y};
      OP_OR:   packed_out = {1'b0, x | y};
      OP_XOR:  packed_out = {1'b0, x ^ y};
      OP_SHL:  packed_out = f_shl(x, y[SHW-1:0]);
      OP_SHR:  packed_out = f_shr(x, y[SHW-1:0]);
      OP_MUL:  packed_out = f_mul(x, y);
      default: packed_out = '0;
    endcase
  end

  assign res = packed_out[W-1:0];
  assign cy  = packed_out[W];
endmodule

// File: rtl/alu_lp_top.sv
module alu_lp_top
  import alu_lp_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         enable,
  input  logic [2:0]   opcode,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] result,
  output logic         zero,
  output logic         carry
);
  // Named internal events for the assertions.
  logic         gate_req;
  logic         gclk;
  logic [W-1:0] a_iso;
  logic [W-1:0] b_iso;
  logic [W-1:0] dp_res;
  logic         dp_cy;
  logic         dp_zero;
  alu_op_e      op_sel;

  // Reset must reach the registers even while the unit is disabled.
  assign gate_req = enable | rst;
  assign op_sel   = alu_op_e'(opcode);

  alu_clock_gate u_cg (
    .clk      (clk),
    .gate_req (gate_req),
    .gclk     (gclk)
  );

  alu_operand_isolate #(.W(W)) u_iso (
    .active (enable),
    .a_in   (a),
    .b_in   (b),
    .a_out  (a_iso),
    .b_out  (b_iso)
  );

  alu_datapath #(.W(W)) u_dp (
    .op  (op_sel),
    .x   (a_iso),
    .y   (b_iso),
    .res (dp_res),
    .cy  (dp_cy)
  );

  assign dp_zero = (dp_res == '0);

  always_ff @(posedge gclk) begin
    if (rst) begin
      result <= '0;
      zero   <= 1'b0;
      carry  <= 1'b0;
    end else begin
      result <= dp_res;
      zero   <= dp_zero;
      carry  <= dp_cy;
    end
  end

  assert_reset_clears_R11: assert property (@(posedge clk)
    rst |=> (result == '0) && !zero && !carry);

  assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !enable |=> $stable(result) && $stable(zero) && $stable(carry));

  assert_isolated_datapath_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !enable |-> (dp_res == '0) && !dp_cy);

  assert_zero_flag_matches_R7: assert property (@(posedge clk) disable iff (rst)
    $past(enable && !rst) |-> (zero == (result == '0)));

  assert_logic_ops_no_carry_R3: assert property (@(posedge clk) disable iff (rst)
    $past(enable && !rst && (opcode == 3'b010 || opcode == 3'b011 || opcode == 3'b100))
      |-> !carry);
endmodule

// File: tb/alu_lp_top_tb.sv
module alu_lp_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enable = 1'b0;
  logic [2:0]  opcode = 3'b000;
  logic [15:0] a = '0;
  logic [15:0] b = '0;
  logic [15:0] result;
  logic        zero;
  logic        carry;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  alu_lp_top u_dut (
    .clk(clk), .rst(rst), .enable(enable), .opcode(opcode),
    .a(a), .b(b), .result(result), .zero(zero), .carry(carry)
  );

  logic [15:0] ops [10] = '{16'h0000, 16'h0001, 16'hFFFF, 16'h8000, 16'h7FFF,
                            16'hAAAA, 16'h5555, 16'h1234, 16'h00FF, 16'hFF00};

  // Reference model in 32-bit integer arithmetic: returns {carry, result}.
  function automatic logic [16:0] model(input int op, input int x, input int y);
    int r; int c; int n;
    n = y & 15;
    case (op)
      0: begin r = x + y; c = (r > 65535) ? 1 : 0; end
      1: begin r = x - y; c = (x < y) ? 1 : 0; end
      2: begin r = x & y; c = 0; end
      3: begin r = x | y; c = 0; end
      4: begin r = x ^ y; c = 0; end
      5: begin r = x << n; c = (n == 0) ? 0 : ((x >> (16 - n)) & 1); end
      6: begin r = x >> n; c = (n == 0) ? 0 : ((x >> (n - 1)) & 1); end
      default: begin r = x * y; c = (((r >> 16) & 32'hFFFF) != 0) ? 1 : 0; end
    endcase
    return {c[0], r[15:0]};
  endfunction

  task automatic check(input string tag, input logic [15:0] er, input logic ez, input logic ec);
    tests++;
    if (result !== er || zero !== ez || carry !== ec) begin
      fails++;
      $display("FAIL %s: got res=%h z=%b c=%b expected res=%h z=%b c=%b",
               tag, result, zero, carry, er, ez, ec);
    end
  endtask

  // Apply at a falling edge, check at the next falling edge (one rising edge later).
  task automatic run_op(input string tag, input int op, input logic [15:0] x, input logic [15:0] y);
    logic [16:0] e;
    @(negedge clk);
    enable = 1'b1; opcode = op[2:0]; a = x; b = y;
    e = model(op, int'(x), int'(y));
    @(negedge clk);
    check(tag, e[15:0], e[15:0] == 16'h0, e[16]);
  endtask

  function automatic string tag_of(input int op);
    case (op)
      0: return "R1 add";
      1: return "R2 sub";
      2, 3, 4: return "R3 logic";
      5: return "R4 shl";
      6: return "R5 shr";
      default: return "R6 mul";
    endcase
  endfunction

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] held_r; logic held_z; logic held_c;
    // R11: reset state
    @(negedge clk); @(negedge clk);
    check("R11 reset", 16'h0, 1'b0, 1'b0);
    rst = 1'b0;

    // R1..R6, R7, R8: operand cross over every opcode
    for (int op = 0; op < 8; op++)
      for (int i = 0; i < 10; i++)
        for (int j = 0; j < 10; j++)
          run_op(tag_of(op), op, ops[i], ops[j]);

    // R4, R5: every shift amount on every operand
    for (int i = 0; i < 10; i++)
      for (int n = 0; n < 16; n++) begin
        run_op("R4 shl sweep", 5, ops[i], 16'(n) | 16'hFFF0);
        run_op("R5 shr sweep", 6, ops[i], 16'(n));
      end

    // R7: wrap-around to zero sets the zero flag with carry
    run_op("R7 zero by wrap", 0, 16'hFFFF, 16'h0001);
    check("R7 zero flag", 16'h0000, 1'b1, 1'b1);

    // R9: hold while disabled under changing inputs
    run_op("R8 setup", 0, 16'h1200, 16'h0034);
    held_r = result; held_z = zero; held_c = carry;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      enable = 1'b0; opcode = k[2:0]; a = ops[k]; b = ops[9 - k];
      @(negedge clk);
      check("R9 hold idle", held_r, held_z, held_c);
    end

    // R10: enable raised during the high phase gives no early update
    @(negedge clk);
    enable = 1'b0; opcode = 3'b000; a = 16'h0100; b = 16'h0001;
    @(posedge clk); #1;
    enable = 1'b1;
    @(negedge clk);
    check("R10 no mid-cycle edge", held_r, held_z, held_c);
    @(negedge clk);
    check("R10 next edge updates", 16'h0101, 1'b0, 1'b0);

    // R11: reset while disabled
    @(negedge clk);
    enable = 1'b0; rst = 1'b1;
    @(negedge clk);
    check("R11 reset while idle", 16'h0, 1'b0, 1'b0);
    rst = 1'b0;

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule